// File: doc/BRIEF.md
# Hardware Breakpoint Match and Status Unit

This block compares four breakpoint slots against processor events every cycle. Each slot has an address register and fields inside a shared 32-bit control word: two enable bits, a two-bit kind and a two-bit length code. Three kinds of event are checked. An instruction fetch matches on an exact address. A data access matches on byte-range overlap and on whether it is a write. An I/O port access matches on overlap against the slot's port range.

From these matches the unit forms the next value of the debug status register and a debug-exception request, both registered. Fetch and data matches rewrite the low hit bits only when an enabled slot hit or the update is forced. When they do, every matching slot is flagged, including disabled ones. An enabled I/O hit always replaces the low hit bits with the mask of I/O slots that hit. A single-step input forces the update, sets the step status bit and requests the exception.

The surrounding core owns the status register. It feeds the current value in on `status_in` and writes `status_out` back when `status_we` is high.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status_out`, `status_we` and `exc_req` are all zero.
- R2: Slot i is enabled when control bit 2i or control bit 2i+1 is set; either bit alone suffices.
- R3: Slot i takes its kind from control bits [17+4i:16+4i] and its length code from bits [19+4i:18+4i]; length codes 0, 1, 3 give 1, 2, 4 bytes and code 2 gives 8 bytes.
- R4: A kind-0 slot matches when `fetch_valid` is high and `fetch_addr` equals the slot address.
- R5: A kind-1 slot matches data writes and a kind-3 slot matches data reads and writes, when `data_valid` is high and the access bytes overlap the slot's range; `data_size` codes 0, 1, 2, 3 mean 1, 2, 4, 8 bytes.
- R6: A kind-2 slot that is enabled hits when `io_valid` is high and port..port+size-1 overlaps the slot range (`io_size` uses the same encoding as `data_size`); any such hit replaces status bits [3:0] with the I/O hit mask and requests the exception.
- R7: For fetch and data events, status bits [3:0] become the mask of all matching slots, enabled or not, but only when an enabled slot matched or the update is forced; otherwise no write and no exception.
- R8: `step` forces the fetch/data status update, sets status bit 14 and requests the exception.
- R9: When an I/O hit falls in the same cycle as a fetch/data update or a step, the I/O mask wins in bits [3:0] and bit 14 set by the step is kept.
- R10: Outputs follow their inputs by one clock. `exc_req` is high only in the cycle after an event cycle. Status bits not named above pass through from `status_in` unchanged, and with no write `status_out` equals the previous `status_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 32 | Slot enables, kinds and length codes |
| slot_addr_flat | input | 128 | Four 32-bit slot addresses, slot 0 in the low bits |
| fetch_valid | input | 1 | Instruction fetch event present |
| fetch_addr | input | 32 | Fetch address |
| data_valid | input | 1 | Data access event present |
| data_addr | input | 32 | First byte of the data access |
| data_size | input | 2 | Data access size code |
| data_write | input | 1 | Data access is a write |
| io_valid | input | 1 | I/O port access present |
| io_port | input | 16 | First port of the I/O access |
| io_size | input | 2 | I/O access size code |
| step | input | 1 | Single-step trap request |
| status_in | input | 32 | Current status register value |
| status_out | output | 32 | Next status register value |
| status_we | output | 1 | Status write-back enable |
| exc_req | output | 1 | Debug exception request pulse |

## Verification
A single step and an enabled I/O hit can fall in the same cycle, and so can an enabled fetch hit and an I/O hit. Both would write bits [3:0]. The bench drives these pairs together on one cycle. Its behavioural model applies the step/fetch update first and the I/O replacement after, so bits [3:0] are expected to carry only the I/O mask while bit 14 stays set. The model's values are compared on every clock.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

    localparam int unsigned KIND_BASE = 16;
    localparam int unsigned LEN_BASE  = 18;
    localparam int unsigned FIELD_STRIDE = 4;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_WR    = 2'd1,
        KIND_IO    = 2'd2,
        KIND_RW    = 2'd3
    } kind_e;

    typedef struct packed {
        logic       en;
        kind_e      kind;
        logic [3:0] nbytes;
    } slot_cfg_t;

    function automatic logic [3:0] code_to_bytes(input logic [1:0] code);
        return (code == 2'd2) ? 4'd8 : ({2'b00, code} + 4'd1);
    endfunction

    function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/dbgm_slot_decode.sv
module dbgm_slot_decode
    import dbgm_pkg::*;
#(
    parameter int unsigned NSLOT = 4,
    localparam int unsigned CW = KIND_BASE + FIELD_STRIDE * NSLOT
) (
    input  logic [CW-1:0]               ctrl,
    output slot_cfg_t [NSLOT-1:0]       cfg
);

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^ctrl[KIND_BASE-1:2*NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_comb begin
            cfg[g].en     = ctrl[2*g] | ctrl[2*g+1];
            cfg[g].kind   = kind_e'(ctrl[KIND_BASE + FIELD_STRIDE*g +: 2]);
            cfg[g].nbytes = code_to_bytes(ctrl[LEN_BASE + FIELD_STRIDE*g +: 2]);
        end
    end

endmodule

// File: rtl/dbgm_slot_match.sv
module dbgm_slot_match
    import dbgm_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned PW = 16,
    localparam int unsigned XW = AW + 5
) (
    input  slot_cfg_t      cfg,
    input  logic [AW-1:0]  slot_addr,
    input  logic           fetch_valid,
    input  logic [AW-1:0]  fetch_addr,
    input  logic           data_valid,
    input  logic [AW-1:0]  data_addr,
    input  logic [1:0]     data_size,
    input  logic           data_write,
    input  logic           io_valid,
    input  logic [PW-1:0]  io_port,
    input  logic [1:0]     io_size,
    output logic           fd_hit,
    output logic           io_hit
);

    logic [XW-1:0] s_lo, s_hi, d_lo, d_hi, p_lo, p_hi;
    logic          d_overlap, p_overlap, kind_ok;

    always_comb begin
        s_lo = XW'(slot_addr);
        s_hi = s_lo + XW'(cfg.nbytes) - XW'(1);
        d_lo = XW'(data_addr);
        d_hi = d_lo + XW'(size_to_bytes(data_size)) - XW'(1);
        p_lo = XW'(io_port);
        p_hi = p_lo + XW'(size_to_bytes(io_size)) - XW'(1);
        d_overlap = (d_hi >= s_lo) && (d_lo <= s_hi);
        p_overlap = (p_hi >= s_lo) && (p_lo <= s_hi);
        kind_ok   = (cfg.kind == KIND_RW) || ((cfg.kind == KIND_WR) && data_write);
        fd_hit = (fetch_valid && (cfg.kind == KIND_FETCH) && (slot_addr == fetch_addr))
               || (data_valid && kind_ok && d_overlap);
        io_hit = io_valid && cfg.en && (cfg.kind == KIND_IO) && p_overlap;
    end

endmodule

// File: rtl/dbgm_status_merge.sv
module dbgm_status_merge #(
    parameter int unsigned NSLOT    = 4,
    parameter int unsigned SW       = 32,
    parameter int unsigned STEP_BIT = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SW-1:0]    status_in,
    input  logic [NSLOT-1:0] fd_mask,
    input  logic [NSLOT-1:0] en_mask,
    input  logic [NSLOT-1:0] io_mask,
    input  logic             step,
    output logic [SW-1:0]    status_out,
    output logic             status_we,
    output logic             exc_req
);

    logic [SW-1:0] nxt;
    logic          fd_update, io_any;

    always_comb begin
        fd_update = (|(fd_mask & en_mask)) || step;
        io_any    = |io_mask;
        nxt       = status_in;
        if (fd_update) begin
            nxt[NSLOT-1:0] = fd_mask;
            if (step) nxt[STEP_BIT] = 1'b1;
        end
        if (io_any) nxt[NSLOT-1:0] = io_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_out <= '0;
            status_we  <= 1'b0;
            exc_req    <= 1'b0;
        end else begin
            status_out <= nxt;
            status_we  <= fd_update || io_any;
            exc_req    <= fd_update || io_any;
        end
    end

    // R8: a step yields the request and the step bit one cycle later
    assert_step_sets_bit_R8: assert property (@(posedge clk) disable iff (rst)
        step |=> (exc_req && status_out[STEP_BIT]));

    // R6 and R9: an I/O hit owns the low hit bits
    assert_io_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (|io_mask) |=> (exc_req && status_out[NSLOT-1:0] == $past(io_mask)));

    // R7: only disabled matches and no step -> nothing written or requested
    assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!step && io_mask == '0 && (fd_mask & en_mask) == '0)
        |=> (!exc_req && !status_we && status_out == $past(status_in)));

    // R10: upper status bits are passed through on a write
    assert_upper_keep_R10: assert property (@(posedge clk) disable iff (rst)
        status_we |-> status_out[SW-1:STEP_BIT+1] == $past(status_in[SW-1:STEP_BIT+1]));

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbgm_pkg::*;
#(
    parameter int unsigned NSLOT    = 4,
    parameter int unsigned AW       = 32,
    parameter int unsigned PW       = 16,
    parameter int unsigned SW       = 32,
    parameter int unsigned STEP_BIT = 14,
    localparam int unsigned CW = KIND_BASE + FIELD_STRIDE * NSLOT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CW-1:0]       ctrl_word,
    input  logic [NSLOT*AW-1:0] slot_addr_flat,
    input  logic                fetch_valid,
    input  logic [AW-1:0]       fetch_addr,
    input  logic                data_valid,
    input  logic [AW-1:0]       data_addr,
    input  logic [1:0]          data_size,
    input  logic                data_write,
    input  logic                io_valid,
    input  logic [PW-1:0]       io_port,
    input  logic [1:0]          io_size,
    input  logic                step,
    input  logic [SW-1:0]       status_in,
    output logic [SW-1:0]       status_out,
    output logic                status_we,
    output logic                exc_req
);

    slot_cfg_t [NSLOT-1:0] cfg;
    logic [NSLOT-1:0]      fd_mask, io_mask, en_mask;

    dbgm_slot_decode #(.NSLOT(NSLOT)) u_decode (
        .ctrl (ctrl_word),
        .cfg  (cfg)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_match
        assign en_mask[g] = cfg[g].en;
        dbgm_slot_match #(.AW(AW), .PW(PW)) u_match (
            .cfg         (cfg[g]),
            .slot_addr   (slot_addr_flat[g*AW +: AW]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .data_valid  (data_valid),
            .data_addr   (data_addr),
            .data_size   (data_size),
            .data_write  (data_write),
            .io_valid    (io_valid),
            .io_port     (io_port),
            .io_size     (io_size),
            .fd_hit      (fd_mask[g]),
            .io_hit      (io_mask[g])
        );
    end

    dbgm_status_merge #(.NSLOT(NSLOT), .SW(SW), .STEP_BIT(STEP_BIT)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .status_in  (status_in),
        .fd_mask    (fd_mask),
        .en_mask    (en_mask),
        .io_mask    (io_mask),
        .step       (step),
        .status_out (status_out),
        .status_we  (status_we),
        .exc_req    (exc_req)
    );

endmodule

// File: tb/dbg_bkpt_unit_bench.sv
`timescale 1ns/1ps
module dbg_bkpt_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic [31:0] sa [4];
    logic [127:0] slot_addr_flat;
    logic        fetch_valid = 0, data_valid = 0, data_write = 0, io_valid = 0, step = 0;
    logic [31:0] fetch_addr = '0, data_addr = '0, status_in = '0;
    logic [1:0]  data_size = '0, io_size = '0;
    logic [15:0] io_port = '0;
    logic [31:0] status_out;
    logic        status_we, exc_req;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] exp_status;
    logic        exp_we, exp_exc;

    always #4 clk = ~clk;

    assign slot_addr_flat = {sa[3], sa[2], sa[1], sa[0]};

    dbg_bkpt_unit u_dbg_bkpt_unit (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .slot_addr_flat(slot_addr_flat),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .data_valid(data_valid), .data_addr(data_addr), .data_size(data_size),
        .data_write(data_write), .io_valid(io_valid), .io_port(io_port),
        .io_size(io_size), .step(step), .status_in(status_in),
        .status_out(status_out), .status_we(status_we), .exc_req(exc_req)
    );

    // behavioural reference written from the requirements
    task automatic predict();
        int fdm = 0, enm = 0, iom = 0;
        for (int i = 0; i < 4; i++) begin
            int ebits = (ctrl_word >> (2*i)) & 3;
            int kind  = (ctrl_word >> (16 + 4*i)) & 3;
            int lcode = (ctrl_word >> (18 + 4*i)) & 3;
            longint len = (lcode == 2) ? 8 : lcode + 1;
            longint base = longint'(sa[i]);
            longint dlo = longint'(data_addr);
            longint dn  = longint'(1) << data_size;
            longint plo = longint'(io_port);
            longint pn  = longint'(1) << io_size;
            if (ebits != 0) enm |= (1 << i);
            if (fetch_valid && kind == 0 && sa[i] == fetch_addr) fdm |= (1 << i);
            if (data_valid && ((kind == 1 && data_write) || kind == 3)
                && dlo + dn - 1 >= base && dlo <= base + len - 1) fdm |= (1 << i);
            if (io_valid && ebits != 0 && kind == 2
                && plo + pn - 1 >= base && plo <= base + len - 1) iom |= (1 << i);
        end
        exp_status = status_in;
        exp_we = 1'b0;
        if ((fdm & enm) != 0 || step) begin
            exp_status = (exp_status & ~32'hF) | 32'(fdm);
            if (step) exp_status = exp_status | 32'h4000;
            exp_we = 1'b1;
        end
        if (iom != 0) begin
            exp_status = (exp_status & ~32'hF) | 32'(iom);
            exp_we = 1'b1;
        end
        exp_exc = exp_we;
    endtask

    task automatic check3(input string tag);
        n_checks += 3;
        if (status_out !== exp_status) begin
            n_fail++;
            $display("FAIL %s status_out actual=%h expected=%h", tag, status_out, exp_status);
        end
        if (status_we !== exp_we) begin
            n_fail++;
            $display("FAIL %s status_we actual=%b expected=%b", tag, status_we, exp_we);
        end
        if (exc_req !== exp_exc) begin
            n_fail++;
            $display("FAIL %s exc_req actual=%b expected=%b", tag, exc_req, exp_exc);
        end
    endtask

    // inputs are set at a falling edge; the result is sampled one clock later
    task automatic tick(input string tag);
        predict();
        @(posedge clk);
        @(negedge clk);
        check3(tag);
    endtask

    task automatic quiet();
        fetch_valid = 0; data_valid = 0; io_valid = 0; step = 0; data_write = 0;
    endtask

    task automatic set_slot(input int i, input int ebits, input int kind, input int lcode);
        ctrl_word[2*i +: 2]    = 2'(ebits);
        ctrl_word[16+4*i +: 2] = 2'(kind);
        ctrl_word[18+4*i +: 2] = 2'(lcode);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) sa[i] = '0;
        repeat (3) @(negedge clk);
        exp_status = '0; exp_we = 0; exp_exc = 0;
        check3("R1 during reset");
        rst = 1'b0;
        @(negedge clk);
        check3("R1 after reset");

        // R4 and R2: local enable, fetch equal
        sa[0] = 32'h1000; set_slot(0, 1, 0, 0);
        status_in = 32'hA5A0_0000;
        fetch_valid = 1; fetch_addr = 32'h1000;
        tick("R4 R2 fetch hit local enable");
        quiet();
        tick("R10 request ends after one cycle");
        fetch_valid = 1; fetch_addr = 32'h1001;
        tick("R4 fetch address differs");

        // R7: disabled slot matches only
        set_slot(0, 0, 0, 0); fetch_addr = 32'h1000;
        tick("R7 disabled match does not write");

        // R7, R2: global enable plus disabled match flagged
        sa[1] = 32'h2000; set_slot(1, 2, 0, 0);
        sa[2] = 32'h2000; set_slot(2, 0, 0, 0);
        status_in = 32'hA5A0_0009; fetch_addr = 32'h2000;
        tick("R7 R2 global enable, disabled slot flagged");
        quiet();

        // R3 and R5: 8-byte write slot
        sa[3] = 32'h3000; set_slot(3, 1, 1, 2);
        data_valid = 1; data_write = 1; data_size = 0; data_addr = 32'h3007;
        tick("R3 R5 last byte of 8-byte range");
        data_addr = 32'h3008;
        tick("R3 R5 just past 8-byte range");
        data_addr = 32'h2FFE; data_size = 2;
        tick("R5 4-byte write straddles start");
        data_write = 0; data_addr = 32'h3004; data_size = 0;
        tick("R5 read ignored by write-only slot");
        set_slot(3, 1, 3, 2);
        tick("R5 read hits read-write slot");
        set_slot(3, 1, 3, 3);
        tick("R3 4-byte length misses 0x3004");
        set_slot(3, 1, 3, 0); data_addr = 32'h2FFF; data_size = 3;
        tick("R3 R5 1-byte slot inside 8-byte access");
        quiet();

        // R6: I/O slots
        sa[2] = 32'h60; set_slot(2, 1, 2, 3);
        status_in = 32'h0000_800F;
        io_valid = 1; io_port = 16'h5E; io_size = 1;
        tick("R6 2-byte access below range");
        io_size = 2;
        tick("R6 4-byte access overlaps range");
        io_port = 16'h64; io_size = 0;
        tick("R6 port past range");
        io_port = 16'h63; set_slot(2, 0, 2, 3);
        tick("R6 disabled I/O slot");
        quiet();

        // R8 single step
        status_in = 32'h1234_0F0F; step = 1;
        tick("R8 single step alone");
        quiet();
        tick("R10 idle passes status through");

        // R9 same-cycle combinations
        set_slot(2, 2, 2, 1); io_valid = 1; io_port = 16'h61; io_size = 0;
        step = 1;
        tick("R9 step and I/O hit together");
        quiet();
        set_slot(0, 1, 0, 0); fetch_valid = 1; fetch_addr = 32'h1000;
        io_valid = 1; io_port = 16'h60;
        tick("R9 fetch hit and I/O hit together");
        quiet();
        rst = 1'b1;
        exp_status = '0; exp_we = 0; exp_exc = 0;
        @(posedge clk); @(negedge clk);
        check3("R1 reset clears outputs again");
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule